// File: doc/BRIEF.md
# CAN Double-Buffered Receive Slot Pair

This block holds two CAN receive mailboxes. A separate bit-level decoder hands it one finished frame at a time: identifier, format flag, data or remote type, DLC and payload. The block checks each frame against a single shared filter, which has one identifier, one bit mask and one format setting. If the frame passes, the block writes it into one of its two slots. When the pairing mode is on, accepted frames go to slot 0, then slot 1, then slot 0 again, and so on. This lets the host read one slot while the next frame lands in the other.

When the pairing mode is off, only slot 0 receives, and it takes data frames only. A loopback option lets frames that this node sends itself be stored as if they had come in from the bus. Frames from the bus produce an acknowledge request, and looped frames never do. The configuration is taken only while the controller is held in its reset state. Each slot has a full flag, which the host clears with a read acknowledge. Writing a frame into a slot that is still full replaces its contents and raises an overrun flag.

Top module: `can_rx_pair`

## Requirements
- R1: While `ctl_hold` is 1, no frame is stored. One edge after `ctl_hold` is sampled high, both full flags and both overrun flags read 0 and the slot pointer is back at slot 0.
- R2: `cfg_pair_en` and `cfg_loop_en` are captured only on edges where `ctl_hold` is 1. Changing them while `ctl_hold` is 0 has no effect on how frames are routed.
- R3: A frame passes the filter only when `frm_ext` equals `flt_ext` and every identifier bit whose `flt_mask` bit is 1 equals the matching `flt_id` bit. A mask bit of 0 ignores that bit. For standard frames (`frm_ext`=0) only bits [10:0] are compared. For extended frames all 29 bits are compared.
- R4: In pairing mode, accepted frames are written alternately to slot 0 and slot 1. The first frame after `ctl_hold` is released goes to slot 0.
- R5: In pairing mode, both data frames (`frm_rtr`=0) and remote frames (`frm_rtr`=1) are accepted.
- R6: With pairing off, only data frames are accepted, they are always written to slot 0, and slot 1 is never written.
- R7: A store copies identifier, format, type, DLC and payload into the slot. The slot's full flag reads 1 from the next cycle on.
- R8: `host_ack[i]` clears the full and overrun flags of slot i. If a store hits the same slot in the same cycle, the store wins: full reads 1 and overrun reads 0.
- R9: A store into a slot that is already full, with no acknowledge in that cycle, overwrites the slot and sets its overrun flag. The flag stays set until it is acknowledged.
- R10: A frame with `frm_from_tx`=1 is considered for storage only when loopback was enabled. Otherwise it is ignored.
- R11: `ack_req` is 1 in the same cycle as `frm_valid` when the frame comes from the bus (`frm_from_tx`=0) and `ctl_hold` is 0. It is 0 for looped frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_hold | input | 1 | Controller held in its reset state |
| cfg_pair_en | input | 1 | Pairing (double-buffer) mode request |
| cfg_loop_en | input | 1 | Loopback request |
| flt_id | input | 29 | Filter identifier |
| flt_mask | input | 29 | Filter mask, 1 = compare the bit |
| flt_ext | input | 1 | Filter format, 1 = extended |
| frm_valid | input | 1 | Decoded frame present this cycle |
| frm_from_tx | input | 1 | Frame is this node's own transmission |
| frm_id | input | 29 | Frame identifier |
| frm_ext | input | 1 | Frame format, 1 = extended |
| frm_rtr | input | 1 | 1 = remote frame |
| frm_dlc | input | 4 | Data length code |
| frm_data | input | 64 | Payload |
| host_ack | input | 2 | Read acknowledge per slot |
| ack_req | output | 1 | Request to acknowledge the frame on the bus |
| slot_id | output | 2x29 | Stored identifier per slot |
| slot_ext | output | 2 | Stored format per slot |
| slot_rtr | output | 2 | Stored type per slot |
| slot_dlc | output | 2x4 | Stored DLC per slot |
| slot_data | output | 2x64 | Stored payload per slot |
| slot_full | output | 2 | Slot holds an unread frame |
| slot_ovr | output | 2 | Unread frame was overwritten |

## Verification
The hardest case to reach from the ports is a store that lands on a full slot in the same cycle the host acknowledges it. Reaching it needs the pointer to be in a known position and the slot to already hold an unread frame. Directed sequences first fill both slots and then issue a matching frame together with an acknowledge on the targeted slot. Random cycles also raise acknowledges often enough to meet stores by chance. A second case is a configuration change while the controller is running; the stimulus flips the mode inputs outside the hold window and then sends remote frames that only pairing mode would accept.

// File: rtl/can_rxp_pkg.sv
package can_rxp_pkg;
  parameter int ID_W   = 29;
  parameter int STD_W  = 11;
  parameter int DLC_W  = 4;
  parameter int DATA_W = 64;
  parameter int NSLOT  = 2;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic              ext;
    logic              rtr;
    logic [DLC_W-1:0]  dlc;
    logic [DATA_W-1:0] data;
  } frame_t;

  // bits of the identifier that take part in the compare for a given format
  function automatic logic [ID_W-1:0] id_span(input logic ext);
    logic [ID_W-1:0] s;
    s = '0;
    s[STD_W-1:0] = '1;
    if (ext) s = '1;
    return s;
  endfunction

  function automatic logic id_accept(input logic [ID_W-1:0] id, input logic ext,
                                     input logic [ID_W-1:0] fid, input logic [ID_W-1:0] fmask,
                                     input logic fext);
    return (ext == fext) && (((id ^ fid) & fmask & id_span(ext)) == '0);
  endfunction
endpackage

// File: rtl/can_rxp_filter.sv
module can_rxp_filter import can_rxp_pkg::*; (
  input  logic [ID_W-1:0] id,
  input  logic            ext,
  input  logic [ID_W-1:0] fid,
  input  logic [ID_W-1:0] fmask,
  input  logic            fext,
  output logic            hit
);
  assign hit = id_accept(id, ext, fid, fmask, fext);
endmodule

// File: rtl/can_rxp_slot.sv
module can_rxp_slot import can_rxp_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   wr,
  input  logic   ack,
  input  frame_t frm_in,
  output frame_t frm_q,
  output logic   full_q,
  output logic   ovr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (clr) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (wr) begin
      frm_q  <= frm_in;
      full_q <= 1'b1;
      ovr_q  <= ack ? 1'b0 : (ovr_q | full_q);
    end else if (ack) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end
  end

  assert_store_sets_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && wr |=> full_q && frm_q == $past(frm_in));
  assert_overrun_on_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && wr && full_q && !ack |=> ovr_q);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && ack && !wr |=> !full_q && !ovr_q);
  assert_ovr_needs_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> full_q);
endmodule

// File: rtl/can_rx_pair.sv
module can_rx_pair import can_rxp_pkg::*; (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctl_hold,
  input  logic                         cfg_pair_en,
  input  logic                         cfg_loop_en,
  input  logic [ID_W-1:0]              flt_id,
  input  logic [ID_W-1:0]              flt_mask,
  input  logic                         flt_ext,
  input  logic                         frm_valid,
  input  logic                         frm_from_tx,
  input  logic [ID_W-1:0]              frm_id,
  input  logic                         frm_ext,
  input  logic                         frm_rtr,
  input  logic [DLC_W-1:0]             frm_dlc,
  input  logic [DATA_W-1:0]            frm_data,
  input  logic [NSLOT-1:0]             host_ack,
  output logic                         ack_req,
  output logic [NSLOT-1:0][ID_W-1:0]   slot_id,
  output logic [NSLOT-1:0]             slot_ext,
  output logic [NSLOT-1:0]             slot_rtr,
  output logic [NSLOT-1:0][DLC_W-1:0]  slot_dlc,
  output logic [NSLOT-1:0][DATA_W-1:0] slot_data,
  output logic [NSLOT-1:0]             slot_full,
  output logic [NSLOT-1:0]             slot_ovr
);
  localparam int PTR_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic             pair_q, loop_q;
  logic [PTR_W-1:0] ptr_q;
  logic             id_hit, src_ok, type_ok, accept;
  logic [PTR_W-1:0] tgt;
  logic [NSLOT-1:0] store_vec;
  frame_t           frm_in;

  assign frm_in = '{id: frm_id, ext: frm_ext, rtr: frm_rtr, dlc: frm_dlc, data: frm_data};

  can_rxp_filter u_filter (
    .id(frm_id), .ext(frm_ext), .fid(flt_id), .fmask(flt_mask), .fext(flt_ext), .hit(id_hit)
  );

  assign src_ok  = !frm_from_tx || loop_q;
  assign type_ok = pair_q || !frm_rtr;
  assign accept  = frm_valid && !ctl_hold && src_ok && type_ok && id_hit;
  assign tgt     = pair_q ? ptr_q : '0;
  assign ack_req = frm_valid && !frm_from_tx && !ctl_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= 1'b0;
      loop_q <= 1'b0;
      ptr_q  <= '0;
    end else if (ctl_hold) begin
      pair_q <= cfg_pair_en;
      loop_q <= cfg_loop_en;
      ptr_q  <= '0;
    end else if (accept && pair_q) begin
      ptr_q  <= (ptr_q == PTR_W'(NSLOT - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    frame_t sq;
    assign store_vec[i] = accept && (tgt == PTR_W'(i));
    can_rxp_slot u_slot (
      .clk(clk), .rst_n(rst_n), .clr(ctl_hold), .wr(store_vec[i]), .ack(host_ack[i]),
      .frm_in(frm_in), .frm_q(sq), .full_q(slot_full[i]), .ovr_q(slot_ovr[i])
    );
    assign slot_id[i]   = sq.id;
    assign slot_ext[i]  = sq.ext;
    assign slot_rtr[i]  = sq.rtr;
    assign slot_dlc[i]  = sq.dlc;
    assign slot_data[i] = sq.data;
  end

  assert_hold_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_hold |=> ptr_q == '0 && slot_full == '0 && slot_ovr == '0);
  assert_cfg_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_hold |=> $stable(pair_q) && $stable(loop_q));
  assert_store_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(store_vec));
  assert_pair_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_q && !ctl_hold && store_vec[NSLOT-1] |=> ptr_q == '0);
  assert_single_slot0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_q |-> store_vec[NSLOT-1:1] == '0);
  assert_own_no_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frm_from_tx |-> !ack_req);
  assert_loop_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_from_tx && !loop_q |-> store_vec == '0);
endmodule

// File: tb/can_rx_pair_test.sv
`timescale 1ns/1ps
module can_rx_pair_test;
  import can_rxp_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_hold, cfg_pair_en, cfg_loop_en, flt_ext;
  logic [ID_W-1:0] flt_id, flt_mask, frm_id;
  logic frm_valid, frm_from_tx, frm_ext, frm_rtr;
  logic [DLC_W-1:0] frm_dlc;
  logic [DATA_W-1:0] frm_data;
  logic [1:0] host_ack;
  logic ack_req;
  logic [1:0][ID_W-1:0] slot_id;
  logic [1:0] slot_ext, slot_rtr, slot_full, slot_ovr;
  logic [1:0][DLC_W-1:0] slot_dlc;
  logic [1:0][DATA_W-1:0] slot_data;

  always #4 clk = ~clk;

  can_rx_pair uut (.*);

  int checks = 0, errors = 0;
  bit m_pair, m_loop, m_ptr;
  bit [1:0] m_full, m_ovr;
  logic [ID_W-1:0] m_id[2];
  logic m_ext[2], m_rtr[2];
  logic [DLC_W-1:0] m_dlc[2];
  logic [DATA_W-1:0] m_data[2];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bitwise acceptance walk, restated from R3
  function automatic bit exp_hit(input logic [ID_W-1:0] id, input logic ext);
    if (ext !== flt_ext) return 0;
    for (int b = 0; b < ID_W; b++)
      if (flt_mask[b] && (ext || b < STD_W) && id[b] !== flt_id[b]) return 0;
    return 1;
  endfunction

  task automatic cycle(input string tag);
    bit acc, t, ex;
    #1;
    ex = frm_valid && !frm_from_tx && !ctl_hold;
    chk(ack_req === ex, {tag, "/R11"}, "ack_req", 64'(ack_req), 64'(ex));
    acc = frm_valid && !ctl_hold && (!frm_from_tx || m_loop) && (m_pair || !frm_rtr)
          && exp_hit(frm_id, frm_ext);
    t = m_pair ? m_ptr : 1'b0;
    @(posedge clk);
    if (ctl_hold) begin
      m_pair = cfg_pair_en; m_loop = cfg_loop_en; m_ptr = 0; m_full = 0; m_ovr = 0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (acc && t == i) begin
          m_ovr[i] = host_ack[i] ? 1'b0 : (m_ovr[i] | m_full[i]);
          m_full[i] = 1'b1;
          m_id[i] = frm_id; m_ext[i] = frm_ext; m_rtr[i] = frm_rtr;
          m_dlc[i] = frm_dlc; m_data[i] = frm_data;
        end else if (host_ack[i]) begin
          m_full[i] = 0; m_ovr[i] = 0;
        end
      end
      if (acc && m_pair) m_ptr = ~m_ptr;
    end
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(slot_full[i] === m_full[i], {tag, "/R4"}, $sformatf("full%0d", i), 64'(slot_full[i]), 64'(m_full[i]));
      chk(slot_ovr[i] === m_ovr[i], {tag, "/R9"}, $sformatf("ovr%0d", i), 64'(slot_ovr[i]), 64'(m_ovr[i]));
      chk(slot_id[i] === m_id[i] && slot_ext[i] === m_ext[i] && slot_rtr[i] === m_rtr[i]
          && slot_dlc[i] === m_dlc[i], {tag, "/R7"}, $sformatf("hdr%0d", i),
          {slot_id[i], slot_ext[i], slot_rtr[i], slot_dlc[i]}, {m_id[i], m_ext[i], m_rtr[i], m_dlc[i]});
      chk(slot_data[i] === m_data[i], {tag, "/R7"}, $sformatf("data%0d", i), slot_data[i], m_data[i]);
    end
  endtask

  task automatic idle();
    frm_valid = 0; frm_from_tx = 0; host_ack = 0;
  endtask

  task automatic send(input logic [ID_W-1:0] id, input logic ext, input logic rtr, input logic own);
    frm_valid = 1; frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_from_tx = own;
    frm_dlc = DLC_W'($urandom_range(0, 8)); frm_data = {$urandom, $urandom};
  endtask

  task automatic hold_cfg(input logic pair, input logic loop);
    idle(); ctl_hold = 1; cfg_pair_en = pair; cfg_loop_en = loop;
    cycle("R1");
    ctl_hold = 0;
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "WD", "watchdog", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 2; i++) begin
      m_id[i] = '0; m_ext[i] = 0; m_rtr[i] = 0; m_dlc[i] = '0; m_data[i] = '0;
    end
    idle(); ctl_hold = 1; cfg_pair_en = 1; cfg_loop_en = 0;
    flt_id = 29'h0000_05A3; flt_mask = '1; flt_ext = 0;
    frm_id = '0; frm_ext = 0; frm_rtr = 0; frm_dlc = '0; frm_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cycle("R1"); // reset state and config capture
    ctl_hold = 0;
    // R2: flip config while running; a remote frame must still be taken (pairing stays on)
    cfg_pair_en = 0; cfg_loop_en = 1;
    send(29'h5A3, 0, 1, 0); cycle("R2");
    send(29'h5A3, 0, 0, 1); cycle("R2"); // loop still off: own frame ignored
    // R4 / R5: alternation, remote and data frames, wrap back with overrun
    send(29'h1FFF_F5A3, 0, 0, 0); cycle("R5"); // upper bits ignored for standard
    send(29'h5A3, 0, 1, 0); cycle("R4");
    send(29'h5A3, 0, 0, 0); cycle("R9");
    // R8: store and acknowledge on the same full slot
    send(29'h5A3, 0, 0, 0); host_ack = 2'b01; cycle("R8");
    idle(); host_ack = 2'b11; cycle("R8");
    // R3: mismatching bit, masked-off bit, wrong format
    send(29'h5A2, 0, 0, 0); cycle("R3");
    flt_mask = 29'h7FE; send(29'h5A2, 0, 0, 0); cycle("R3");
    send(29'h5A3, 1, 0, 0); cycle("R3");
    flt_mask = '1;
    // R10: loopback on stores own frames
    hold_cfg(1, 1);
    send(29'h5A3, 0, 0, 1); cycle("R10");
    // R6: pairing off
    hold_cfg(0, 0);
    send(29'h5A3, 0, 1, 0); cycle("R6");
    send(29'h5A3, 0, 0, 0); cycle("R6");
    send(29'h5A3, 0, 0, 0); cycle("R6");
    // extended format filter
    flt_ext = 1; flt_id = 29'h1234_5678; hold_cfg(1, 0);
    send(29'h1234_5678, 1, 0, 0); cycle("R3");
    send(29'h0234_5678, 1, 0, 0); cycle("R3");
    // constrained random
    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom_range(0, 63) == 0) begin
        flt_ext = 1'($urandom); flt_id = ID_W'($urandom);
        flt_mask = ($urandom_range(0, 1) != 0) ? '1 : ID_W'($urandom);
        hold_cfg(1'($urandom), 1'($urandom));
      end else begin
        if ($urandom_range(0, 3) != 0) begin
          logic [ID_W-1:0] id;
          id = ID_W'($urandom);
          if ($urandom_range(0, 3) != 0) id = (id & ~flt_mask) | (flt_id & flt_mask);
          send(id, ($urandom_range(0, 7) == 0) ? ~flt_ext : flt_ext, 1'($urandom),
               $urandom_range(0, 3) == 0);
        end
        if ($urandom_range(0, 3) == 0) host_ack = 2'($urandom);
        cycle("RND");
      end
    end
    idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule